// File: doc/BRIEF.md
# Staged Bit-Permutation Unit

This block rearranges the bits of a 64-bit operand through a chain of fixed stages. Each stage moves or merges bits over one power-of-two distance, and one bit of a control value switches that stage on. An opcode picks one of four operations. Generalized reverse swaps neighbouring groups. Generalized OR-combine merges each group with its partner. Perfect shuffle interleaves groups, and unshuffle undoes the interleave. The control value comes either from the low bits of a register operand or from a 6-bit immediate.

A word mode limits every operation to the low 32 bits of the operand and clears the upper half of the result. The operation itself is combinational. The result is captured in a register together with a valid flag, so each accepted request produces its answer one clock later.

Top module: `bitperm_unit`

## Requirements
- R1: With opcode 00 (reverse), result bit i equals operand bit (i XOR c), where c is the effective control. With c = 63, the bits are fully reversed; with c = 56, the bytes are reversed.
- R2: With opcode 01 (OR-combine), result bit i is the OR of every operand bit j for which (i XOR j) has set bits only in positions set in c.
- R3: With opcode 10 (shuffle), stages are applied for control weights 16, 8, 4, 2, 1 in that order. The stage of weight N keeps bits outside its masks L and R, moves x<<N into L and moves x>>N into R. The L/R masks are: 0x0000ffff00000000/0x00000000ffff0000 for weight 16, 0x00ff000000ff0000/0x0000ff000000ff00 for weight 8, 0x0f000f000f000f00/0x00f000f000f000f0 for weight 4, repeated 0x30/0x0c bytes for weight 2, and repeated 0x44/0x22 bytes for weight 1.
- R4: With opcode 11 (unshuffle), the same stages are applied in the order 1, 2, 4, 8, 16. Unshuffling a shuffled value with the same control gives back the original value.
- R5: The effective control keeps 6 bits for reverse and OR-combine and 5 bits for shuffle and unshuffle. Higher control bits have no effect.
- R6: When word_mode is 1, only operand bits 31..0 take part, the control is limited to 5 bits (reverse, OR-combine) or 4 bits (shuffle, unshuffle), and result bits 63..32 are 0.
- R7: When use_imm is 1, the control is taken from ctrl_imm. Otherwise it is taken from the low bits of ctrl_reg, and ctrl_imm is ignored.
- R8: res_valid is 1 exactly in the cycle after a cycle with in_valid = 1. When in_valid is 0, res holds its value.
- R9: While rst_n is low, res_valid and res are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 reverse, 01 OR-combine, 10 shuffle, 11 unshuffle |
| word_mode | input | 1 | 1 = operate on the low 32 bits |
| use_imm | input | 1 | 1 = control from ctrl_imm |
| src | input | 64 | Operand |
| ctrl_reg | input | 64 | Control register value (low bits used) |
| ctrl_imm | input | 6 | Immediate control value |
| res_valid | output | 1 | Result valid |
| res | output | 64 | Registered result |

## Verification
The result register is the only state, so a fault in a stage, a mask or the control selection shows on res one cycle after the request that exposes it. A stage with a wrong mask or shift distance is only visible when its control bit is set. For this reason the vectors cover single stages, full-control cases and mixed controls in both widths. A shuffle stage applied in the wrong order breaks the shuffle/unshuffle round trip, and this is checked with an unshuffle that follows directly after the shuffle. A wrong valid or hold path shows in the cycle straight after a request or an idle cycle.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  typedef enum logic [1:0] {
    OP_REV    = 2'b00,
    OP_ORC    = 2'b01,
    OP_SHFL   = 2'b10,
    OP_UNSHFL = 2'b11
  } perm_op_e;
endpackage

// File: rtl/bitperm_ctrl.sv
module bitperm_ctrl
  import bitperm_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int STAGES = $clog2(XLEN)
) (
  input  perm_op_e          op,
  input  logic              word_mode,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   ctrl_reg,
  input  logic [STAGES-1:0] ctrl_imm,
  output logic [STAGES-1:0] ctrl_eff
);
  localparam logic [STAGES-1:0] FULL_MASK   = '1;
  localparam logic [STAGES-1:0] WORD_MASK   = STAGES'((1 << (STAGES - 1)) - 1);
  localparam logic [STAGES-1:0] SHFL_MASK   = STAGES'((1 << (STAGES - 1)) - 1);
  localparam logic [STAGES-1:0] SHFLW_MASK  = STAGES'((1 << (STAGES - 2)) - 1);

  logic [STAGES-1:0] raw;
  logic [STAGES-1:0] keep;
  logic              unused_ctrl_hi;

  assign unused_ctrl_hi = ^ctrl_reg[XLEN-1:STAGES];
  assign raw = use_imm ? ctrl_imm : ctrl_reg[STAGES-1:0];

  always_comb begin
    unique case (op)
      OP_REV, OP_ORC: keep = word_mode ? WORD_MASK : FULL_MASK;
      default:        keep = word_mode ? SHFLW_MASK : SHFL_MASK;
    endcase
  end

  assign ctrl_eff = raw & keep;

  always_comb begin
    if (op == OP_SHFL || op == OP_UNSHFL)
      assert_shfl_ctrl_width_R5: assert (ctrl_eff[STAGES-1] == 1'b0);
  end
endmodule

// File: rtl/bitperm_grev_net.sv
module bitperm_grev_net #(
  parameter int XLEN   = 64,
  parameter int STAGES = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   x,
  input  logic [STAGES-1:0] ctrl,
  input  logic              or_mode,
  output logic [XLEN-1:0]   y
);
  function automatic logic [XLEN-1:0] low_group_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (((i >> k) & 1) == 0);
    return m;
  endfunction

  logic [XLEN-1:0] v [0:STAGES];
  assign v[0] = x;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [XLEN-1:0] LO = low_group_mask(k);
    localparam int              SH = 1 << k;
    logic [XLEN-1:0] swapped;
    assign swapped = ((v[k] & LO) << SH) | ((v[k] & ~LO) >> SH);
    assign v[k+1]  = !ctrl[k] ? v[k] : (or_mode ? (v[k] | swapped) : swapped);
  end

  assign y = v[STAGES];

  always_comb begin
    if (or_mode)
      assert_orc_keeps_ones_R2: assert ((x & ~y) == '0);
    else
      assert_rev_keeps_count_R1: assert ($countones(y) == $countones(x));
  end
endmodule

// File: rtl/bitperm_shfl_net.sv
module bitperm_shfl_net #(
  parameter int XLEN   = 64,
  parameter int SSTG   = $clog2(XLEN) - 1
) (
  input  logic [XLEN-1:0] x,
  input  logic [SSTG-1:0] ctrl,
  input  logic            inverse,
  output logic [XLEN-1:0] y
);
  function automatic logic [XLEN-1:0] left_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++)
      m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    return m;
  endfunction

  function automatic logic [XLEN-1:0] right_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++)
      m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    return m;
  endfunction

  logic [XLEN-1:0] fwd [0:SSTG];
  logic [XLEN-1:0] inv [0:SSTG];
  assign fwd[0] = x;
  assign inv[0] = x;

  for (genvar t = 0; t < SSTG; t++) begin : g_stage
    localparam int              KF = SSTG - 1 - t;
    localparam int              KI = t;
    localparam logic [XLEN-1:0] LF = left_mask(KF);
    localparam logic [XLEN-1:0] RF = right_mask(KF);
    localparam logic [XLEN-1:0] LI = left_mask(KI);
    localparam logic [XLEN-1:0] RI = right_mask(KI);
    logic [XLEN-1:0] fwd_mv;
    logic [XLEN-1:0] inv_mv;
    assign fwd_mv = (fwd[t] & ~(LF | RF)) | ((fwd[t] << (1 << KF)) & LF)
                  | ((fwd[t] >> (1 << KF)) & RF);
    assign inv_mv = (inv[t] & ~(LI | RI)) | ((inv[t] << (1 << KI)) & LI)
                  | ((inv[t] >> (1 << KI)) & RI);
    assign fwd[t+1] = ctrl[KF] ? fwd_mv : fwd[t];
    assign inv[t+1] = ctrl[KI] ? inv_mv : inv[t];
  end

  assign y = inverse ? inv[SSTG] : fwd[SSTG];

  always_comb begin
    assert_shfl_keeps_count_R3: assert ($countones(y) == $countones(x));
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               op,
  input  logic                     word_mode,
  input  logic                     use_imm,
  input  logic [XLEN-1:0]          src,
  input  logic [XLEN-1:0]          ctrl_reg,
  input  logic [$clog2(XLEN)-1:0]  ctrl_imm,
  output logic                     res_valid,
  output logic [XLEN-1:0]          res
);
  localparam int STAGES = $clog2(XLEN);
  localparam int HALF   = XLEN / 2;

  perm_op_e          op_e;
  logic [STAGES-1:0] ctrl_eff;
  logic [XLEN-1:0]   operand;
  logic [XLEN-1:0]   grev_y;
  logic [XLEN-1:0]   shfl_y;
  logic [XLEN-1:0]   net_y;
  logic [XLEN-1:0]   res_nx;
  logic              is_shfl;
  logic              valid_q;
  logic [XLEN-1:0]   res_q;

  assign op_e    = perm_op_e'(op);
  assign is_shfl = (op_e == OP_SHFL) || (op_e == OP_UNSHFL);
  assign operand = word_mode ? {{HALF{1'b0}}, src[HALF-1:0]} : src;

  bitperm_ctrl #(.XLEN(XLEN), .STAGES(STAGES)) u_ctrl (
    .op        (op_e),
    .word_mode (word_mode),
    .use_imm   (use_imm),
    .ctrl_reg  (ctrl_reg),
    .ctrl_imm  (ctrl_imm),
    .ctrl_eff  (ctrl_eff)
  );

  bitperm_grev_net #(.XLEN(XLEN), .STAGES(STAGES)) u_grev (
    .x       (operand),
    .ctrl    (ctrl_eff),
    .or_mode (op_e == OP_ORC),
    .y       (grev_y)
  );

  bitperm_shfl_net #(.XLEN(XLEN), .SSTG(STAGES - 1)) u_shfl (
    .x       (operand),
    .ctrl    (ctrl_eff[STAGES-2:0]),
    .inverse (op_e == OP_UNSHFL),
    .y       (shfl_y)
  );

  always_comb begin
    net_y  = is_shfl ? shfl_y : grev_y;
    res_nx = word_mode ? {{HALF{1'b0}}, net_y[HALF-1:0]} : net_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (in_valid) res_q <= res_nx;
  end

  assign res_valid = valid_q;
  assign res       = res_q;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));
  assert_word_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_mode) |=> (res[XLEN-1:HALF] == '0));
endmodule

// File: tb/tb_bitperm_unit.sv
module tb_bitperm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic        word_mode;
  logic        use_imm;
  logic [63:0] src;
  logic [63:0] ctrl_reg;
  logic [5:0]  ctrl_imm;
  logic        res_valid;
  logic [63:0] res;

  int n_total = 0;
  int n_pass  = 0;

  always #2 clk = ~clk;

  bitperm_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .word_mode(word_mode), .use_imm(use_imm), .src(src),
    .ctrl_reg(ctrl_reg), .ctrl_imm(ctrl_imm),
    .res_valid(res_valid), .res(res)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        w;
    logic        imm;
    logic [5:0]  cimm;
    logic [63:0] creg;
    logic [63:0] x;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 6'd0,  64'd63, 64'h1, 64'h8000000000000000},
    '{2'd0, 1'b0, 1'b0, 6'd0,  64'd32, 64'h0123456789ABCDEF, 64'h89ABCDEF01234567},
    '{2'd0, 1'b0, 1'b0, 6'd0,  64'd56, 64'h0123456789ABCDEF, 64'hEFCDAB8967452301},
    '{2'd0, 1'b0, 1'b1, 6'd7,  64'd0,  64'h1, 64'h80},
    '{2'd0, 1'b0, 1'b1, 6'd63, 64'd0,  64'h1, 64'h8000000000000000},
    '{2'd0, 1'b0, 1'b0, 6'd63, 64'd32, 64'h1, 64'h0000000100000000},
    '{2'd1, 1'b0, 1'b0, 6'd0,  64'd7,  64'h0000000100000080, 64'h000000FF000000FF},
    '{2'd1, 1'b0, 1'b0, 6'd0,  64'd63, 64'h0000000000010000, 64'hFFFFFFFFFFFFFFFF},
    '{2'd2, 1'b0, 1'b0, 6'd0,  64'hFFFFFFFFFFFFFFFF, 64'h00000000FFFFFFFF, 64'h5555555555555555},
    '{2'd3, 1'b0, 1'b1, 6'd31, 64'd0,  64'h5555555555555555, 64'h00000000FFFFFFFF},
    '{2'd2, 1'b0, 1'b0, 6'd0,  64'd16, 64'h00000000FFFF0000, 64'h0000FFFF00000000},
    '{2'd0, 1'b1, 1'b0, 6'd0,  64'hFF, 64'hFFFFFFFF00000001, 64'h0000000080000000},
    '{2'd1, 1'b1, 1'b0, 6'd0,  64'd31, 64'hFFFFFFFF00000010, 64'h00000000FFFFFFFF},
    '{2'd2, 1'b1, 1'b0, 6'd0,  64'h1F, 64'h123456780000FFFF, 64'h0000000055555555},
    '{2'd3, 1'b1, 1'b1, 6'd15, 64'd0,  64'h0000000055555555, 64'h000000000000FFFF},
    '{2'd0, 1'b1, 1'b0, 6'd0,  64'h20, 64'h0000AAAA00001234, 64'h0000000000001234}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_total++;
    if (got === exp) n_pass++;
    else $display("FAIL %s: got %h expected %h", tag, got, exp);
  endtask

  task automatic issue(input logic [1:0] o, input logic w, input logic im,
                       input logic [5:0] ci, input logic [63:0] cr, input logic [63:0] x,
                       output logic [63:0] got, output logic gv);
    @(negedge clk);
    op = o; word_mode = w; use_imm = im; ctrl_imm = ci; ctrl_reg = cr; src = x;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    got = res; gv = res_valid;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] ref_rev(input logic [63:0] x, input int c, input logic w);
    logic [63:0] y = '0;
    int cc = w ? (c & 31) : (c & 63);
    if (w) x[63:32] = '0;
    for (int i = 0; i < 64; i++) y[i] = x[i ^ cc];
    if (w) y[63:32] = '0;
    return y;
  endfunction

  function automatic logic [63:0] ref_orc(input logic [63:0] x, input int c, input logic w);
    logic [63:0] y = '0;
    int cc = w ? (c & 31) : (c & 63);
    if (w) x[63:32] = '0;
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        if (((i ^ j) & ~cc & 63) == 0) y[i] = y[i] | x[j];
    if (w) y[63:32] = '0;
    return y;
  endfunction

  function automatic logic [63:0] one_stage(input logic [63:0] x, input int k);
    logic [63:0] l, r;
    case (k)
      4: begin l = 64'h0000ffff00000000; r = 64'h00000000ffff0000; end
      3: begin l = 64'h00ff000000ff0000; r = 64'h0000ff000000ff00; end
      2: begin l = 64'h0f000f000f000f00; r = 64'h00f000f000f000f0; end
      1: begin l = 64'h3030303030303030; r = 64'h0c0c0c0c0c0c0c0c; end
      default: begin l = 64'h4444444444444444; r = 64'h2222222222222222; end
    endcase
    return (x & ~(l | r)) | ((x << (1 << k)) & l) | ((x >> (1 << k)) & r);
  endfunction

  function automatic logic [63:0] ref_shfl(input logic [63:0] x, input int c,
                                           input logic w, input logic inv);
    int cc = w ? (c & 15) : (c & 31);
    if (w) x[63:32] = '0;
    for (int s = 0; s < 5; s++) begin
      int k = inv ? s : 4 - s;
      if ((cc >> k) & 1) x = one_stage(x, k);
    end
    if (w) x[63:32] = '0;
    return x;
  endfunction

  initial begin
    #(4 * 150000);
    n_total++;
    $display("FAIL watchdog R8: got timeout expected completion");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    logic [63:0] got, got2, exp, lfsr;
    logic        gv;
    rst_n = 1'b0; in_valid = 1'b0; op = 2'd0; word_mode = 1'b0; use_imm = 1'b0;
    src = '0; ctrl_reg = '0; ctrl_imm = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset res", res, 64'h0);
    check("R9 reset valid", {63'h0, res_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R1..R7 vectors
    for (int v = 0; v < NVEC; v++) begin
      issue(VECS[v].op, VECS[v].w, VECS[v].imm, VECS[v].cimm, VECS[v].creg, VECS[v].x, got, gv);
      check($sformatf("R1/R2/R3/R4/R5/R6/R7 vector %0d", v), got, VECS[v].exp);
      check("R8 valid after request", {63'h0, gv}, 64'h1);
    end

    // R8: idle cycles hold result and drop valid
    issue(2'd0, 1'b0, 1'b0, 6'd0, 64'd63, 64'h3, got, gv);
    @(negedge clk);
    src = 64'hDEADBEEF; ctrl_reg = 64'd1;
    @(posedge clk); #1;
    check("R8 idle valid low", {63'h0, res_valid}, 64'h0);
    check("R8 idle hold", res, 64'hC000000000000000);

    // mixed controls against reference
    lfsr = 64'h9E3779B97F4A7C15;
    for (int n = 0; n < 48; n++) begin
      logic [1:0] o;
      logic       w;
      int         c;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      o = 2'(n % 4); w = n[2]; c = int'(lfsr[61:56]);
      issue(o, w, 1'b0, 6'd0, {lfsr[63:6], 6'(c)}, lfsr ^ 64'h0F1E2D3C4B5A6978, got, gv);
      case (o)
        2'd0: exp = ref_rev(lfsr ^ 64'h0F1E2D3C4B5A6978, c, w);
        2'd1: exp = ref_orc(lfsr ^ 64'h0F1E2D3C4B5A6978, c, w);
        2'd2: exp = ref_shfl(lfsr ^ 64'h0F1E2D3C4B5A6978, c, w, 1'b0);
        default: exp = ref_shfl(lfsr ^ 64'h0F1E2D3C4B5A6978, c, w, 1'b1);
      endcase
      check($sformatf("R1/R2/R3/R4/R6 mixed op %0d", o), got, exp);
    end

    // R4 round trip
    for (int c = 0; c < 32; c += 3) begin
      logic [63:0] x = 64'hA5C3_0F96_1E2D_7B48 ^ (64'(c) << 40);
      issue(2'd2, 1'b0, 1'b1, 6'(c), 64'd0, x, got, gv);
      issue(2'd3, 1'b0, 1'b1, 6'(c), 64'd0, got, got2, gv);
      check("R4 round trip", got2, x);
    end

    // R5: bit 5 ignored for shuffle
    issue(2'd2, 1'b0, 1'b1, 6'd33, 64'd0, 64'h0123456789ABCDEF, got, gv);
    check("R5 shuffle bit5 ignored", got, ref_shfl(64'h0123456789ABCDEF, 1, 1'b0, 1'b0));

    // R9: reset mid-run clears result
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset res", res, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule